// File: doc/BRIEF.md
# Interrupt-Armed Four-Channel DMA Sequencer

This block is a small DMA engine with four channels. Each channel is armed by writing the number of an interrupt source into its vector field. When that source's request flag is pending, the channel can claim it. On a claim the block clears the request flag, reads one unit of 1, 2 or 4 bytes from the channel's source address, writes it to the channel's destination address, and counts down the channel's transfer counter. The request is consumed by the DMA, so the CPU never sees it as an ordinary interrupt.

When the counter runs out, the channel raises an end-of-transfer flag and disarms itself by zeroing its vector. Later requests from that source are then left for the normal interrupt path. A burst flag lets a channel run every remaining unit back to back from a single trigger. A standby input and an interrupt-mask input equal to 7 both keep new claims from being accepted. While either is active, the request flags stay pending.

Each channel is programmed through a simple field write and read port. The field codes are 0 vector, 1 source, 2 destination, 3 count and 4 mode. Memory is reached over a single-beat bus that the system's memory acknowledges.

Top module: `vecdma_core`

## Requirements
- R1: After reset there is no bus request, no done pulse and no end-of-transfer flag, and every channel field reads back as 0.
- R2: A channel whose vector v is nonzero claims when request flag v is pending. In the claim cycle, irq_clr_o pulses only bit v, and the read of the unit follows one cycle later. A channel with vector 0 never claims, and it leaves the flag untouched.
- R3: When several channels can claim in the same cycle, the lowest channel number is served first, then the next, down to channel 3.
- R4: One unit is a read at the source address and then, in the next cycle, a write at the destination address of the same size. The write data equals the read data masked to that size. The mode bits [1:0] select the size: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes, and bus_size_o carries 0, 1 or 2. done_o pulses for one cycle, with the channel number on done_ch_o, in the cycle after the write is acknowledged.
- R5: After each unit, the source and destination registers each advance by the unit size in bytes (full 32-bit add), and the count drops by one.
- R6: If the count left after a unit is nonzero and the burst flag (mode bit 2) is clear, the channel stops. No end-of-transfer flag is set, and the vector is kept.
- R7: When a unit brings the count to zero, the channel's bit in eot_o is set in the same cycle as done_o, and its vector becomes 0. A later request from that source is neither claimed nor cleared.
- R8: With the burst flag set, a single claim runs all remaining units back to back. irq_clr_o pulses only once.
- R9: Only address bits 23:0 reach the bus. The upper 8 bits of the source and destination registers have no effect on the bus address.
- R10: While standby_i is high no claim is accepted. The flag stays pending and is served after standby_i falls.
- R11: While imask_i equals 7 no claim is accepted. The flag stays pending and is served once the mask changes.
- R12: An end-of-transfer flag stays set until a 1 is written to its bit of eot_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | 16 | Pending request flags, one per interrupt source |
| irq_clr_o | output | 16 | One-cycle clear of the claimed source's flag |
| standby_i | input | 1 | Holds new claims while high |
| imask_i | input | 3 | Interrupt mask level; 7 blocks claims |
| cfg_we_i | input | 1 | Field write strobe |
| cfg_ch_i | input | 2 | Channel selected for write and read |
| cfg_sel_i | input | 3 | Field code: 0 vector, 1 source, 2 destination, 3 count, 4 mode |
| cfg_wdata_i | input | 32 | Field write data |
| cfg_rdata_o | output | 32 | Selected field read data |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 24 | Bus byte address |
| bus_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |
| done_o | output | 1 | One-cycle pulse per finished unit |
| done_ch_o | output | 2 | Channel of the finished unit |
| eot_o | output | 4 | Held end-of-transfer flags per channel |
| eot_ack_i | input | 4 | Write-1 clear of end-of-transfer flags |

## Verification
A request flag set at a clock edge is claimed in the same cycle, and the clear pulse is visible before the next edge. The read appears exactly one cycle after the clear, the write one cycle after the read, and done_o one cycle after the write. The end-of-transfer flag and the zeroed vector are visible in the done cycle. The reference model in the bench builds queues of expected clears, bus accesses and done events. It samples every falling edge and records the cycle of each clear, read and write, so that it can check these one-cycle gaps directly. Cases that must not happen (standby, mask 7, disarmed channel) are checked with empty queues, so any clear or bus access there is reported. The flag is also read back as still pending.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [2:0] {
        FLD_VEC  = 3'd0,
        FLD_SRC  = 3'd1,
        FLD_DST  = 3'd2,
        FLD_CNT  = 3'd3,
        FLD_MODE = 3'd4
    } fld_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RD   = 2'd1,
        ENG_WR   = 2'd2
    } eng_st_e;

    // size code 3 behaves as a 4-byte unit
    function automatic logic [1:0] norm_size(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (norm_size(code))
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] code);
        case (norm_size(code))
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vdma_chan.sv
module vdma_chan
    import vdma_pkg::*;
#(
    parameter int VEC_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_fld_i,
    input  logic [31:0]      wr_data_i,
    input  logic             step_i,
    input  logic             eot_ack_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [31:0]      src_o,
    output logic [31:0]      dst_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       size_o,
    output logic             burst_o,
    output logic             eot_o,
    output logic             last_o
);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [31:0]      src;
        logic [31:0]      dst;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       size;
        logic             burst;
        logic             eot;
    } chan_t;

    chan_t ch_q, ch_d;

    always_comb begin
        ch_d = ch_q;
        if (eot_ack_i) begin
            ch_d.eot = 1'b0;
        end
        if (step_i) begin
            ch_d.src = ch_q.src + 32'(size_bytes(ch_q.size));
            ch_d.dst = ch_q.dst + 32'(size_bytes(ch_q.size));
            ch_d.cnt = ch_q.cnt - CNT_W'(1);
            if (ch_q.cnt == CNT_W'(1)) begin
                ch_d.eot = 1'b1;
                ch_d.vec = '0;
            end
        end
        if (wr_en_i) begin
            case (fld_e'(wr_fld_i))
                FLD_VEC:  ch_d.vec = wr_data_i[VEC_W-1:0];
                FLD_SRC:  ch_d.src = wr_data_i;
                FLD_DST:  ch_d.dst = wr_data_i;
                FLD_CNT:  ch_d.cnt = wr_data_i[CNT_W-1:0];
                FLD_MODE: begin
                    ch_d.size  = wr_data_i[1:0];
                    ch_d.burst = wr_data_i[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign vec_o   = ch_q.vec;
    assign src_o   = ch_q.src;
    assign dst_o   = ch_q.dst;
    assign cnt_o   = ch_q.cnt;
    assign size_o  = ch_q.size;
    assign burst_o = ch_q.burst;
    assign eot_o   = ch_q.eot;
    assign last_o  = (ch_q.cnt == CNT_W'(1));

endmodule

// File: rtl/vdma_trig.sv
module vdma_trig #(
    parameter  int NCH   = 4,
    parameter  int VEC_W = 4,
    localparam int NSRC  = 1 << VEC_W,
    localparam int CHW   = $clog2(NCH)
) (
    input  logic [NCH*VEC_W-1:0] vec_flat_i,
    input  logic [NSRC-1:0]      irq_i,
    input  logic                 open_i,
    output logic                 grant_vld_o,
    output logic [CHW-1:0]       grant_ch_o,
    output logic [NSRC-1:0]      clr_mask_o
);

    logic [NCH-1:0] want;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_match
        logic [VEC_W-1:0] vsel;
        assign vsel      = vec_flat_i[gi*VEC_W +: VEC_W];
        assign want[gi]  = (vsel != '0) && irq_i[vsel];
    end

    // walk from the lowest priority up so the smallest index is kept
    always_comb begin
        grant_vld_o = 1'b0;
        grant_ch_o  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (want[i] && open_i) begin
                grant_vld_o = 1'b1;
                grant_ch_o  = CHW'(i);
            end
        end
    end

    always_comb begin
        clr_mask_o = '0;
        if (grant_vld_o) begin
            clr_mask_o[vec_flat_i[int'(grant_ch_o)*VEC_W +: VEC_W]] = 1'b1;
        end
    end

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int CHW    = 2,
    parameter int BUS_AW = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              grant_vld_i,
    input  logic [CHW-1:0]    grant_ch_i,
    input  logic [BUS_AW-1:0] src_i,
    input  logic [BUS_AW-1:0] dst_i,
    input  logic [1:0]        size_i,
    input  logic              burst_i,
    input  logic              last_i,
    input  logic              bus_ack_i,
    input  logic [31:0]       bus_rdata_i,
    output logic              idle_o,
    output logic [CHW-1:0]    cur_ch_o,
    output logic              step_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic [1:0]        bus_size_o,
    output logic [31:0]       bus_wdata_o,
    output logic              done_o,
    output logic [CHW-1:0]    done_ch_o
);

    typedef struct packed {
        eng_st_e        st;
        logic [CHW-1:0] ch;
        logic [31:0]    data;
        logic           done;
        logic [CHW-1:0] done_ch;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        step_o     = 1'b0;
        bus_req_o  = 1'b0;
        bus_we_o   = 1'b0;
        bus_addr_o = '0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (grant_vld_i) begin
                    eng_d.st = ENG_RD;
                    eng_d.ch = grant_ch_i;
                end
            end
            ENG_RD: begin
                bus_req_o  = 1'b1;
                bus_addr_o = src_i;
                if (bus_ack_i) begin
                    eng_d.data = bus_rdata_i & size_mask(size_i);
                    eng_d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b1;
                bus_addr_o = dst_i;
                if (bus_ack_i) begin
                    step_o        = 1'b1;
                    eng_d.done    = 1'b1;
                    eng_d.done_ch = eng_q.ch;
                    eng_d.st      = (burst_i && !last_i) ? ENG_RD : ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign idle_o      = (eng_q.st == ENG_IDLE);
    assign cur_ch_o    = eng_q.ch;
    assign bus_size_o  = norm_size(size_i);
    assign bus_wdata_o = eng_q.data;
    assign done_o      = eng_q.done;
    assign done_ch_o   = eng_q.done_ch;

endmodule

// File: rtl/vecdma_core.sv
module vecdma_core
    import vdma_pkg::*;
#(
    parameter  int NCH    = 4,
    parameter  int VEC_W  = 4,
    parameter  int CNT_W  = 16,
    parameter  int BUS_AW = 24,
    localparam int NSRC   = 1 << VEC_W,
    localparam int CHW    = $clog2(NCH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   irq_pend_i,
    output logic [NSRC-1:0]   irq_clr_o,
    input  logic              standby_i,
    input  logic [2:0]        imask_i,
    input  logic              cfg_we_i,
    input  logic [CHW-1:0]    cfg_ch_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [31:0]       cfg_wdata_i,
    output logic [31:0]       cfg_rdata_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [BUS_AW-1:0] bus_addr_o,
    output logic [1:0]        bus_size_o,
    output logic [31:0]       bus_wdata_o,
    input  logic [31:0]       bus_rdata_i,
    input  logic              bus_ack_i,
    output logic              done_o,
    output logic [CHW-1:0]    done_ch_o,
    output logic [NCH-1:0]    eot_o,
    input  logic [NCH-1:0]    eot_ack_i
);

    logic [VEC_W-1:0]     vec_a   [NCH];
    logic [31:0]          src_a   [NCH];
    logic [31:0]          dst_a   [NCH];
    logic [CNT_W-1:0]     cnt_a   [NCH];
    logic [1:0]           size_a  [NCH];
    logic [NCH-1:0]       burst_a;
    logic [NCH-1:0]       last_a;
    logic [NCH-1:0]       step_a;
    logic [NCH*VEC_W-1:0] vec_flat;

    logic           eng_idle;
    logic [CHW-1:0] eng_ch;
    logic           eng_step;
    logic           grant_vld;
    logic [CHW-1:0] grant_ch;
    logic           claim_open;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        assign step_a[gi] = eng_step && (eng_ch == CHW'(gi));
        assign vec_flat[gi*VEC_W +: VEC_W] = vec_a[gi];

        vdma_chan #(
            .VEC_W (VEC_W),
            .CNT_W (CNT_W)
        ) i_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (cfg_we_i && (cfg_ch_i == CHW'(gi))),
            .wr_fld_i  (cfg_sel_i),
            .wr_data_i (cfg_wdata_i),
            .step_i    (step_a[gi]),
            .eot_ack_i (eot_ack_i[gi]),
            .vec_o     (vec_a[gi]),
            .src_o     (src_a[gi]),
            .dst_o     (dst_a[gi]),
            .cnt_o     (cnt_a[gi]),
            .size_o    (size_a[gi]),
            .burst_o   (burst_a[gi]),
            .eot_o     (eot_o[gi]),
            .last_o    (last_a[gi])
        );
    end

    assign claim_open = eng_idle && !standby_i && (imask_i != 3'd7);

    vdma_trig #(
        .NCH   (NCH),
        .VEC_W (VEC_W)
    ) i_trig (
        .vec_flat_i  (vec_flat),
        .irq_i       (irq_pend_i),
        .open_i      (claim_open),
        .grant_vld_o (grant_vld),
        .grant_ch_o  (grant_ch),
        .clr_mask_o  (irq_clr_o)
    );

    vdma_engine #(
        .CHW    (CHW),
        .BUS_AW (BUS_AW)
    ) i_engine (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .grant_vld_i (grant_vld),
        .grant_ch_i  (grant_ch),
        .src_i       (src_a[eng_ch][BUS_AW-1:0]),
        .dst_i       (dst_a[eng_ch][BUS_AW-1:0]),
        .size_i      (size_a[eng_ch]),
        .burst_i     (burst_a[eng_ch]),
        .last_i      (last_a[eng_ch]),
        .bus_ack_i   (bus_ack_i),
        .bus_rdata_i (bus_rdata_i),
        .idle_o      (eng_idle),
        .cur_ch_o    (eng_ch),
        .step_o      (eng_step),
        .bus_req_o   (bus_req_o),
        .bus_we_o    (bus_we_o),
        .bus_addr_o  (bus_addr_o),
        .bus_size_o  (bus_size_o),
        .bus_wdata_o (bus_wdata_o),
        .done_o      (done_o),
        .done_ch_o   (done_ch_o)
    );

    always_comb begin
        case (fld_e'(cfg_sel_i))
            FLD_VEC:  cfg_rdata_o = 32'(vec_a[cfg_ch_i]);
            FLD_SRC:  cfg_rdata_o = src_a[cfg_ch_i];
            FLD_DST:  cfg_rdata_o = dst_a[cfg_ch_i];
            FLD_CNT:  cfg_rdata_o = 32'(cnt_a[cfg_ch_i]);
            FLD_MODE: cfg_rdata_o = {29'd0, burst_a[cfg_ch_i], size_a[cfg_ch_i]};
            default:  cfg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/vecdma_core_chk.sv
module vecdma_core_chk #(
    parameter int NSRC = 16,
    parameter int NCH  = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [NSRC-1:0] irq_clr_o,
    input logic            standby_i,
    input logic [2:0]      imask_i,
    input logic            bus_req_o,
    input logic            bus_we_o,
    input logic            bus_ack_i,
    input logic            done_o,
    input logic [NCH-1:0]  eot_o
);

    assert_single_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_clr_o))
        else $error("more than one request flag cleared");

    assert_standby_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |-> (irq_clr_o == '0))
        else $error("claim during standby");

    assert_mask_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imask_i == 3'd7) |-> (irq_clr_o == '0))
        else $error("claim with mask level 7");

    assert_write_follows_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_we_o && bus_ack_i) |=> (bus_req_o && bus_we_o))
        else $error("no write after acknowledged read");

    assert_done_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(bus_req_o && bus_we_o && bus_ack_i))
        else $error("done without a preceding write");

    assert_eot_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(eot_o & ~$past(eot_o))) |-> done_o)
        else $error("end-of-transfer flag rose without a done pulse");

endmodule

bind vecdma_core vecdma_core_chk #(
    .NSRC (NSRC),
    .NCH  (NCH)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_clr_o (irq_clr_o),
    .standby_i (standby_i),
    .imask_i   (imask_i),
    .bus_req_o (bus_req_o),
    .bus_we_o  (bus_we_o),
    .bus_ack_i (bus_ack_i),
    .done_o    (done_o),
    .eot_o     (eot_o)
);

// File: tb/test_vecdma_core.sv
module test_vecdma_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_q;
    logic [15:0] irq_set = '0;
    logic [15:0] irq_kill = '0;
    logic [15:0] irq_clr_o;
    logic        standby = 1'b0;
    logic [2:0]  imask = 3'd0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata_o;
    logic        bus_req_o, bus_we_o;
    logic [23:0] bus_addr_o;
    logic [1:0]  bus_size_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        done_o;
    logic [1:0]  done_ch_o;
    logic [3:0]  eot_o;
    logic [3:0]  eot_ack = '0;

    always #10 clk = ~clk;

    vecdma_core i_vecdma_core (
        .clk_i(clk), .rst_ni(rst_n), .irq_pend_i(irq_q), .irq_clr_o(irq_clr_o),
        .standby_i(standby), .imask_i(imask), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
        .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_size_o(bus_size_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata),
        .bus_ack_i(bus_ack), .done_o(done_o), .done_ch_o(done_ch_o), .eot_o(eot_o),
        .eot_ack_i(eot_ack)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_clr_cyc = -10;
    int last_rd_cyc = -10;
    int last_wr_cyc = -10;

    typedef struct {
        bit          we;
        logic [23:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        bit          first;
    } bus_exp_t;

    bus_exp_t exp_bus[$];
    int       exp_clr[$];
    int       exp_done[$];

    always @(posedge clk) cyc <= cyc + 1;

    // request flip-flops of the interrupt sources
    always @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= (irq_q | irq_set) & ~irq_clr_o & ~irq_kill;
    end

    function automatic logic [31:0] pattern(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3, a[23:16] ^ 8'h96, a[7:0] + 8'h11};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model: compares every falling edge against expected events
    always @(negedge clk) begin
        bus_exp_t e;
        int       s;
        int       ch;
        bus_ack = 1'b0;
        if (rst_n) begin
            if (irq_clr_o != '0) begin
                if (exp_clr.size() == 0) begin
                    check("R2 unexpected clear", 32'(irq_clr_o), 32'h0);
                end else begin
                    s = exp_clr.pop_front();
                    check("R2 clear bit", 32'(irq_clr_o), 32'h1 << s);
                end
                last_clr_cyc = cyc;
            end
            if (bus_req_o) begin
                bus_ack = 1'b1;
                if (exp_bus.size() == 0) begin
                    check("R4 unexpected bus access", 32'(bus_addr_o), 32'hFFFF_FFFF);
                end else begin
                    e = exp_bus.pop_front();
                    check("R4 direction", 32'(bus_we_o), 32'(e.we));
                    check("R9 bus address", 32'(bus_addr_o), 32'(e.addr));
                    check("R4 bus size", 32'(bus_size_o), 32'(e.size));
                    if (e.we) begin
                        check("R4 write data", bus_wdata_o, e.data);
                        check("R4 write one cycle after read", 32'(cyc - last_rd_cyc), 32'd1);
                        last_wr_cyc = cyc;
                    end else begin
                        bus_rdata = pattern(bus_addr_o);
                        if (e.first)
                            check("R2 read one cycle after clear", 32'(cyc - last_clr_cyc), 32'd1);
                        last_rd_cyc = cyc;
                    end
                end
            end
            if (done_o) begin
                if (exp_done.size() == 0) begin
                    check("R4 unexpected done", 32'(done_ch_o), 32'hFFFF_FFFF);
                end else begin
                    ch = exp_done.pop_front();
                    check("R4 done channel", 32'(done_ch_o), 32'(ch));
                    check("R4 done one cycle after write", 32'(cyc - last_wr_cyc), 32'd1);
                end
            end
        end
    end

    task automatic push_unit(input int ch, input logic [31:0] src, input logic [31:0] dst,
                             input logic [1:0] sz, input bit first);
        bus_exp_t    r;
        bus_exp_t    w;
        logic [1:0]  n;
        logic [31:0] m;
        n = (sz == 2'd3) ? 2'd2 : sz;
        m = (n == 2'd0) ? 32'hFF : (n == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        r = '{we: 1'b0, addr: src[23:0], size: n, data: 32'h0, first: first};
        w = '{we: 1'b1, addr: dst[23:0], size: n, data: pattern(src[23:0]) & m, first: 1'b0};
        exp_bus.push_back(r);
        exp_bus.push_back(w);
        exp_done.push_back(ch);
    endtask

    task automatic cfg_wr(input int ch, input int sel, input logic [31:0] data);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = data;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int ch, input int sel, output logic [31:0] data);
        @(posedge clk); #2;
        cfg_ch = 2'(ch); cfg_sel = 3'(sel);
        #5 data = cfg_rdata_o;
    endtask

    task automatic setup(input int ch, input int vec, input logic [31:0] src,
                         input logic [31:0] dst, input int cnt, input int mode);
        cfg_wr(ch, 1, src);
        cfg_wr(ch, 2, dst);
        cfg_wr(ch, 3, 32'(cnt));
        cfg_wr(ch, 4, 32'(mode));
        cfg_wr(ch, 0, 32'(vec));
    endtask

    task automatic raise(input logic [15:0] mask);
        @(posedge clk); #2 irq_set = mask;
        @(posedge clk); #2 irq_set = '0;
    endtask

    task automatic drop(input logic [15:0] mask);
        @(posedge clk); #2 irq_kill = mask;
        @(posedge clk); #2 irq_kill = '0;
    endtask

    task automatic ack_eot(input logic [3:0] mask);
        @(posedge clk); #2 eot_ack = mask;
        @(posedge clk); #2 eot_ack = '0;
    endtask

    task automatic drain();
        while (exp_bus.size() != 0 || exp_done.size() != 0 || exp_clr.size() != 0)
            @(posedge clk);
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 bus idle", 32'(bus_req_o), 32'd0);
        check("R1 no done", 32'(done_o), 32'd0);
        check("R1 eot clear", 32'(eot_o), 32'd0);
        cfg_rd(1, 0, rd); check("R1 vector zero", rd, 32'd0);
        cfg_rd(2, 3, rd); check("R1 count zero", rd, 32'd0);
        cfg_rd(3, 1, rd); check("R1 source zero", rd, 32'd0);

        // single units, 2-byte size, upper address byte ignored
        setup(1, 5, 32'hAB00_1000, 32'h0000_0200, 3, 1);
        exp_clr.push_back(5);
        push_unit(1, 32'hAB00_1000, 32'h200, 2'd1, 1'b1);
        raise(16'h0020);
        drain();
        cfg_rd(1, 3, rd); check("R5 count after one unit", rd, 32'd2);
        cfg_rd(1, 1, rd); check("R5 source advanced", rd, 32'hAB00_1002);
        cfg_rd(1, 2, rd); check("R5 destination advanced", rd, 32'h0000_0202);
        cfg_rd(1, 0, rd); check("R6 vector kept", rd, 32'd5);
        check("R6 no eot", 32'(eot_o), 32'd0);
        for (int k = 1; k < 3; k++) begin
            exp_clr.push_back(5);
            push_unit(1, 32'hAB00_1000 + 32'(2 * k), 32'h200 + 32'(2 * k), 2'd1, 1'b1);
            raise(16'h0020);
            drain();
        end
        check("R7 eot set", 32'(eot_o), 32'h2);
        cfg_rd(1, 0, rd); check("R7 vector cleared", rd, 32'd0);
        cfg_rd(1, 3, rd); check("R7 count zero", rd, 32'd0);

        // disarmed channel: request stays for the normal path
        raise(16'h0020);
        repeat (8) @(posedge clk);
        #2 check("R7 flag untouched after disarm", 32'(irq_q[5]), 32'd1);
        drop(16'h0020);
        check("R12 eot held", 32'(eot_o), 32'h2);
        ack_eot(4'h2);
        check("R12 eot cleared by ack", 32'(eot_o), 32'h0);

        // three channels claim together: lowest number first
        setup(0, 3, 32'h0000_0010, 32'h0000_4000, 1, 0);
        setup(2, 7, 32'h0000_0020, 32'h0000_5000, 1, 1);
        setup(3, 9, 32'h0000_0040, 32'h0000_6000, 1, 3);
        exp_clr.push_back(3);
        exp_clr.push_back(7);
        exp_clr.push_back(9);
        push_unit(0, 32'h10, 32'h4000, 2'd0, 1'b1);
        push_unit(2, 32'h20, 32'h5000, 2'd1, 1'b1);
        push_unit(3, 32'h40, 32'h6000, 2'd3, 1'b1);
        raise(16'h0288);
        drain();
        check("R3 all three finished", 32'(eot_o), 32'hD);
        ack_eot(4'hF);

        // burst run crossing the 24-bit boundary
        setup(2, 4, 32'h12FF_FFFC, 32'h0000_3000, 3, 6);
        exp_clr.push_back(4);
        push_unit(2, 32'h12FF_FFFC, 32'h3000, 2'd2, 1'b1);
        push_unit(2, 32'h1300_0000, 32'h3004, 2'd2, 1'b0);
        push_unit(2, 32'h1300_0004, 32'h3008, 2'd2, 1'b0);
        raise(16'h0010);
        drain();
        check("R8 burst end flag", 32'(eot_o), 32'h4);
        cfg_rd(2, 1, rd); check("R5 burst source", rd, 32'h1300_0008);
        cfg_rd(2, 0, rd); check("R8 vector cleared", rd, 32'd0);
        ack_eot(4'h4);

        // standby holds the claim
        setup(0, 3, 32'h0000_0080, 32'h0000_7000, 1, 0);
        @(posedge clk); #2 standby = 1'b1;
        raise(16'h0008);
        repeat (6) @(posedge clk);
        #2 check("R10 flag pending in standby", 32'(irq_q[3]), 32'd1);
        exp_clr.push_back(3);
        push_unit(0, 32'h80, 32'h7000, 2'd0, 1'b1);
        standby = 1'b0;
        drain();
        check("R10 served after standby", 32'(eot_o), 32'h1);
        ack_eot(4'h1);

        // mask level 7 holds the claim
        setup(3, 9, 32'h0000_0100, 32'h0000_8000, 2, 1);
        @(posedge clk); #2 imask = 3'd7;
        raise(16'h0200);
        repeat (6) @(posedge clk);
        #2 check("R11 flag pending with mask 7", 32'(irq_q[9]), 32'd1);
        exp_clr.push_back(9);
        push_unit(3, 32'h100, 32'h8000, 2'd1, 1'b1);
        imask = 3'd3;
        drain();
        check("R6 no eot with count left", 32'(eot_o), 32'h0);
        cfg_rd(3, 3, rd); check("R11 count after masked claim", rd, 32'd1);

        check("end expectation queues empty",
               32'(exp_bus.size() + exp_clr.size() + exp_done.size()), 32'd0);
        summary();
        $finish;
    end

endmodule